// File: doc/BRIEF.md
# Password-Gated Serial Memory Controller

This block is a two-wire serial slave that guards a small memory of 14 sectors, each eight bytes wide and held in registers. There is no device address: the slave listens only while its active-low chip select is asserted. Every transfer opens with a command byte. Next comes an 8-byte password, which the slave compares with either a read password or a write password. Both passwords are 64 bits and both come out of reset as zero.

A completed password load always starts a nonvolatile busy period, whether or not the password was correct. The busy period is timed outside the block: the controller pulses a start output, and an external timer holds a busy input high. The master learns whether the password was accepted only by polling with the 55h command. That poll is acknowledged once the busy period has ended, and only if the password matched. After an acknowledged poll, the same transaction continues in one of three ways:

- **Sector read:** the slave streams bytes and wraps around the whole array.
- **Sector write:** the master sends exactly eight bytes.
- **Password change:** the master sends eight new password bytes.

Any failure returns the controller to standby.

SCL, SDA and chip select are sampled on a fast system clock. The controller pulls SDA low through an open-drain drive output and never drives it high.

Top module: `pwd_serial_mem`

## Requirements
- R1: While reset is held, and directly after it, `sda_low` and `nv_start` are 0.
- R2: The command codes are as follows.
  - `100 s3 s2 s1 s0 0` is a sector write and `100 s3 s2 s1 s0 1` is a sector read, where the sector number is in bits 4..1. A sector number below 14 is legal.
  - FCh changes the write password, FEh changes the read password, and 55h is the poll.
  - A legal command is acknowledged when the block is not busy.
  - Any other code, including sectors 14 and 15, gets no ACK. The controller then ignores every following byte until the next start.
- R3: After a legal access or change command, the controller acknowledges each of the eight password bytes. Bytes are MSB first, and the first byte is the most significant byte of the 64-bit value. When the eighth byte's ACK slot begins, `nv_start` pulses for exactly one clock, whether or not the password matched.
- R4: A 55h poll gets no ACK while `nv_busy` is high.
- R5: A 55h poll is acknowledged only when all three hold: `nv_busy` is low, a full password load has completed, and that password matched. Otherwise the poll gets no ACK.
- R6: A sector read is checked against the read password. A sector write and both password-change commands are checked against the write password.
- R7: The read stream works as follows.
  - It starts at byte 0 of the addressed sector and sends each byte MSB first.
  - SDA changes only while SCL is low.
  - Each master ACK moves the stream to the next byte, across sector boundaries, and wraps from byte 111 to byte 0.
  - A master no-ACK ends the stream.
- R8: A sector write commits only if exactly eight data bytes are followed by a stop; that commit pulses `nv_start`. A ninth byte gets no ACK. With fewer or more than eight bytes, the stop leaves the sector unchanged and gives no pulse.
- R9: After an acknowledged poll for FCh or FEh, eight new bytes followed by a stop replace the write or read password respectively, and `nv_start` pulses.
- R10: Any command byte received while `nv_busy` is high gets no ACK.
- R11: A start or stop that arrives before the eighth password byte aborts the transfer. There is no `nv_start` pulse, and a following 55h poll gets no ACK.
- R12: After reset, every memory byte reads back as 00h and both passwords equal zero.
- R13: Raising `cs_n` releases SDA within a few system clocks and abandons the current transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| scl | input | 1 | Serial clock from the master |
| sda_in | input | 1 | Sampled level of the shared SDA line |
| nv_busy | input | 1 | High while the external write timer runs |
| sda_low | output | 1 | Open-drain drive: 1 pulls SDA low |
| nv_start | output | 1 | One-clock request that starts the write timer |

## Verification
The hardest situation to reach is the poll outcome. It depends on three things together: whether a full password load happened, whether that password matched, and whether the external timer is still running. The bench models the timer itself, so it can send a 55h poll while busy is still high and again after it falls. It also aborts password loads with a start or a stop and then polls. Finally, it changes the read password and then offers both the old and the new value. Reads that run past sector 13, and writes with five or nine data bytes, exercise the wrap and the commit rule at the ports.

// File: rtl/pwd_serial_mem.sv
module pwd_serial_mem #(
  parameter int SECTORS   = 14,
  parameter int SEC_BYTES = 8,
  parameter int PW_BYTES  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic scl,
  input  logic sda_in,
  input  logic nv_busy,
  output logic sda_low,
  output logic nv_start
);
  localparam int MEM_BYTES = SECTORS * SEC_BYTES;
  localparam int AW        = $clog2(MEM_BYTES);
  localparam int PW_BITS   = 8 * PW_BYTES;
  localparam int MAXB      = (SEC_BYTES > PW_BYTES) ? SEC_BYTES : PW_BYTES;
  localparam int HOLDW     = 8 * MAXB;
  localparam int CNTW      = $clog2(MAXB + 2);
  localparam logic [3:0]      SEC_LIM = 4'(SECTORS);
  localparam logic [CNTW-1:0] PW_LAST = CNTW'(PW_BYTES - 1);
  localparam logic [CNTW-1:0] SEC_N   = CNTW'(SEC_BYTES);
  localparam logic [CNTW-1:0] PW_N    = CNTW'(PW_BYTES);
  localparam logic [AW-1:0]   TOP     = AW'(MEM_BYTES - 1);
  localparam logic [7:0] CMD_POLL = 8'h55, CMD_NEW_WPW = 8'hFC, CMD_NEW_RPW = 8'hFE;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_PWD, S_PDONE, S_WDATA, S_NEWPW, S_RD} st_t;
  typedef enum logic [2:0] {OP_NONE, OP_WR, OP_RD, OP_NWP, OP_NRP} op_t;

  logic [2:0] scl_p, sda_p, cs_p;
  st_t  st;
  op_t  op, pend_op, dec_op;
  logic [3:0] sec, pend_sec, bitc;
  logic in_ack, mack, pw_ok;
  logic [7:0] sh;
  logic [HOLDW-1:0] hold, hold_nx;
  logic [CNTW-1:0] cnt, data_lim;
  logic [AW-1:0] addr, nxt, wbase, pbase, rd_pre;
  logic [PW_BITS-1:0] wr_pw, rd_pw, ref_pw;
  logic [7:0] mem [MEM_BYTES];

  wire scl_s = scl_p[1], scl_d = scl_p[2];
  wire sda_s = sda_p[1], sda_d = sda_p[2];
  wire cs_s  = cs_p[1];
  wire rise    = scl_s & ~scl_d;
  wire fall    = ~scl_s & scl_d;
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  wire ack_ent = fall & ~in_ack & (bitc == 4'd8);

  assign hold_nx  = {hold[HOLDW-9:0], sh};
  assign ref_pw   = (op == OP_RD) ? rd_pw : wr_pw;
  assign data_lim = (st == S_WDATA) ? SEC_N : PW_N;
  assign nxt      = (addr == TOP) ? '0 : addr + 1'b1;
  assign wbase    = AW'(32'(sec) * SEC_BYTES);
  assign pbase    = AW'(32'(pend_sec) * SEC_BYTES);
  assign rd_pre   = (pbase == '0) ? TOP : pbase - 1'b1;

  always_comb begin
    dec_op = OP_NONE;
    if (sh[7:5] == 3'b100 && sh[4:1] < SEC_LIM) dec_op = sh[0] ? OP_RD : OP_WR;
    else if (sh == CMD_NEW_WPW) dec_op = OP_NWP;
    else if (sh == CMD_NEW_RPW) dec_op = OP_NRP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1; sda_p <= '1; cs_p <= '1;
      st <= S_IDLE; op <= OP_NONE; pend_op <= OP_NONE;
      sec <= '0; pend_sec <= '0; bitc <= '0;
      in_ack <= 1'b0; mack <= 1'b0; pw_ok <= 1'b0;
      sh <= '0; hold <= '0; cnt <= '0; addr <= '0;
      wr_pw <= '0; rd_pw <= '0;
      sda_low <= 1'b0; nv_start <= 1'b0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else begin
      scl_p <= {scl_p[1:0], scl};
      sda_p <= {sda_p[1:0], sda_in};
      cs_p  <= {cs_p[1:0], cs_n};
      nv_start <= 1'b0;
      if (cs_s) begin
        st <= S_IDLE; sda_low <= 1'b0; in_ack <= 1'b0; bitc <= '0;
      end else if (start_c) begin
        st <= S_CMD; sda_low <= 1'b0; in_ack <= 1'b0; bitc <= '0;
      end else if (stop_c) begin
        if (st == S_WDATA && cnt == SEC_N) begin
          for (int k = 0; k < SEC_BYTES; k++)
            mem[wbase + AW'(k)] <= hold[8*(SEC_BYTES-1-k) +: 8];
          nv_start <= 1'b1;
        end
        if (st == S_NEWPW && cnt == PW_N) begin
          if (op == OP_NRP) rd_pw <= hold[PW_BITS-1:0];
          else              wr_pw <= hold[PW_BITS-1:0];
          nv_start <= 1'b1;
        end
        st <= S_IDLE; sda_low <= 1'b0; in_ack <= 1'b0; bitc <= '0;
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (in_ack) mack <= ~sda_s;
          else if (bitc < 4'd8) begin
            sh <= {sh[6:0], sda_s};
            bitc <= bitc + 1'b1;
          end
        end
        if (fall) begin
          if (in_ack) begin
            in_ack <= 1'b0; bitc <= '0;
            if (st == S_RD) begin
              // a device ACK ends the poll, so the first byte also arrives through mack
              if (mack) begin addr <= nxt; sda_low <= ~mem[nxt][7]; end
              else begin st <= S_IDLE; sda_low <= 1'b0; end
            end else sda_low <= 1'b0;
          end else if (bitc == 4'd8) begin
            in_ack <= 1'b1;
            case (st)
              S_CMD: begin
                if (nv_busy) begin
                  sda_low <= 1'b0; st <= S_IDLE;
                end else if (sh == CMD_POLL) begin
                  pend_op <= OP_NONE;
                  if (pend_op != OP_NONE && pw_ok) begin
                    sda_low <= 1'b1; op <= pend_op; sec <= pend_sec; cnt <= '0;
                    case (pend_op)
                      OP_RD:   begin st <= S_RD; addr <= rd_pre; end
                      OP_WR:   st <= S_WDATA;
                      default: st <= S_NEWPW;
                    endcase
                  end else begin
                    sda_low <= 1'b0; st <= S_IDLE;
                  end
                end else if (dec_op != OP_NONE) begin
                  sda_low <= 1'b1; op <= dec_op; sec <= sh[4:1];
                  cnt <= '0; pend_op <= OP_NONE; st <= S_PWD;
                end else begin
                  sda_low <= 1'b0; st <= S_IDLE;
                end
              end
              S_PWD: begin
                sda_low <= 1'b1; hold <= hold_nx; cnt <= cnt + 1'b1;
                if (cnt == PW_LAST) begin
                  pw_ok <= (hold_nx[PW_BITS-1:0] == ref_pw);
                  pend_op <= op; pend_sec <= sec;
                  nv_start <= 1'b1; st <= S_PDONE;
                end
              end
              S_WDATA, S_NEWPW: begin
                if (cnt < data_lim) begin
                  sda_low <= 1'b1; hold <= hold_nx; cnt <= cnt + 1'b1;
                end else begin
                  sda_low <= 1'b0; cnt <= data_lim + 1'b1;
                end
              end
              default: sda_low <= 1'b0;
            endcase
          end else if (st == S_RD) begin
            sda_low <= ~mem[addr][3'd7 - bitc[2:0]];
          end
        end
      end
    end
  end

  p_cs_release_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sda_low);
  p_nv_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |=> !nv_start);
  p_busy_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ent && !cs_s && st == S_CMD && nv_busy) |=> !sda_low);
  p_bad_pw_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ent && !cs_s && st == S_CMD && sh == CMD_POLL && !pw_ok) |=> !sda_low);
  p_sda_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_d && !cs_s && !$past(cs_s)) |-> $stable(sda_low));
  p_addr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr <= TOP);
endmodule

// File: tb/sim_pwd_serial_mem.sv
module sim_pwd_serial_mem;
  timeunit 1ns; timeprecision 1ps;
  localparam int H = 8;
  localparam int BUSY_CYC = 600;
  localparam logic [63:0] P = 64'h1122334455667788;
  // {command byte, expected ACK}
  localparam logic [8:0] VEC [16] = '{
    {8'h80, 1'b1}, {8'h81, 1'b1}, {8'h9A, 1'b1}, {8'h9B, 1'b1},
    {8'h9C, 1'b0}, {8'h9D, 1'b0}, {8'h9E, 1'b0}, {8'h9F, 1'b0},
    {8'hFC, 1'b1}, {8'hFE, 1'b1}, {8'hFD, 1'b0}, {8'hFF, 1'b0},
    {8'h00, 1'b0}, {8'hA0, 1'b0}, {8'h55, 1'b0}, {8'h7F, 1'b0}};

  logic clk = 0, rst_n = 0, cs_n = 1, scl = 1, m_low = 0, busy = 0;
  logic dut_low, nv_start, sda_bus;
  int nchk = 0, nfail = 0, npulse = 0, bcnt = 0;

  assign sda_bus = ~(m_low | dut_low);
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (nv_start) begin busy <= 1'b1; bcnt <= BUSY_CYC; npulse <= npulse + 1; end
    else if (bcnt > 0) bcnt <= bcnt - 1;
    else busy <= 1'b0;
  end

  pwd_serial_mem u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .scl(scl), .sda_in(sda_bus),
                     .nv_busy(busy), .sda_low(dut_low), .nv_start(nv_start));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_h(); repeat (H) @(posedge clk); #1; endtask
  task automatic bus_start(); m_low = 0; wait_h(); scl = 1; wait_h(); m_low = 1; wait_h(); scl = 0; wait_h(); endtask
  task automatic bus_stop(); m_low = 1; wait_h(); scl = 1; wait_h(); m_low = 0; wait_h(); endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wait_h(); scl = 1; wait_h(); scl = 0;
    end
    m_low = 0; wait_h(); scl = 1; wait_h(); ack = ~sda_bus; scl = 0; wait_h();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      wait_h(); scl = 1; wait_h(); b[i] = sda_bus; scl = 0;
    end
    m_low = mack; wait_h(); scl = 1; wait_h(); scl = 0; m_low = 0; wait_h();
  endtask

  task automatic send_pw(input logic [7:0] cmd, input logic [63:0] pw, output logic all_ack);
    logic a;
    bus_start(); send_byte(cmd, a); all_ack = a;
    for (int i = 7; i >= 0; i--) begin send_byte(pw[8*i +: 8], a); all_ack &= a; end
    bus_stop();
  endtask

  task automatic poll(output logic ack); bus_start(); send_byte(8'h55, ack); endtask
  task automatic wait_idle(); while (busy) @(posedge clk); repeat (4) @(posedge clk); #1; endtask

  task automatic write_sec(input logic [7:0] cmd, input logic [7:0] first, input int n,
                           input string req);
    logic a;
    int p0;
    send_pw(cmd, 64'd0, a); wait_idle();
    poll(a); check({req, " poll ack"}, a, 1);
    p0 = npulse;
    for (int k = 0; k < n; k++) begin
      send_byte(first + 8'(k), a);
      check({req, " data ack"}, a, (k < 8) ? 1 : 0);
    end
    bus_stop(); repeat (4) @(posedge clk); #1;
    check({req, " commit pulse"}, npulse - p0, (n == 8) ? 1 : 0);
    wait_idle();
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    int p0;
    repeat (5) @(posedge clk); #1;
    check("R1 sda released in reset", dut_low, 0);
    check("R1 nv_start low in reset", nv_start, 0);
    rst_n = 1; cs_n = 0; wait_h();
    check("R1 sda released after reset", dut_low, 0);

    for (int i = 0; i < 16; i++) begin
      bus_start(); send_byte(VEC[i][8:1], a);
      check("R2 command ack", a, VEC[i][0]);
      if (!VEC[i][0]) begin send_byte(8'h80, a); check("R2 standby after illegal", a, 0); end
      bus_stop();
    end

    p0 = npulse;
    send_pw(8'h81, 64'd0, a);
    check("R3 password bytes acked", a, 1);
    check("R3 one pulse per load", npulse - p0, 1);
    poll(a); check("R4 poll nack while busy", a, 0); bus_stop();
    wait_idle(); poll(a); check("R5 poll ack on match", a, 1);
    for (int k = 0; k < 8; k++) begin recv_byte(k != 7, b); check("R12 reset memory zero", b, 0); end
    bus_stop();

    write_sec(8'h9A, 8'hD0, 8, "R8 sector13");
    write_sec(8'h80, 8'h30, 8, "R8 sector0");

    send_pw(8'h9B, 64'd0, a); wait_idle(); poll(a); check("R6 read pw zero ack", a, 1);
    for (int k = 0; k < 16; k++) begin
      recv_byte(k != 15, b);
      check("R7 wrap 13 to 0", b, (k < 8) ? 8'hD0 + 8'(k) : 8'h30 + 8'(k - 8));
    end
    bus_stop();

    send_pw(8'h99, 64'd0, a); wait_idle(); poll(a);
    for (int k = 0; k < 9; k++) begin
      recv_byte(k != 8, b);
      check("R7 cross sector", b, (k < 8) ? 8'h00 : 8'hD0);
    end
    bus_stop();

    write_sec(8'h80, 8'h50, 5, "R8 short");
    write_sec(8'h80, 8'h60, 9, "R8 long");
    send_pw(8'h81, 64'd0, a); wait_idle(); poll(a);
    for (int k = 0; k < 8; k++) begin recv_byte(k != 7, b); check("R8 sector0 unchanged", b, 8'h30 + 8'(k)); end
    bus_stop();

    send_pw(8'h80, 64'd0, a);
    bus_start(); send_byte(8'h81, a); check("R10 command nack while busy", a, 0); bus_stop();
    wait_idle();

    send_pw(8'hFE, 64'd0, a); wait_idle(); poll(a); check("R9 change poll ack", a, 1);
    p0 = npulse;
    for (int i = 7; i >= 0; i--) begin send_byte(P[8*i +: 8], a); check("R9 new pw byte ack", a, 1); end
    bus_stop(); repeat (4) @(posedge clk); #1;
    check("R9 change pulse", npulse - p0, 1);
    wait_idle();
    send_pw(8'h81, 64'd0, a); wait_idle(); poll(a); check("R5 old read pw rejected", a, 0); bus_stop();
    send_pw(8'h81, P, a); wait_idle(); poll(a); check("R9 new read pw accepted", a, 1);
    recv_byte(1'b0, b); check("R9 read after change", b, 8'h30); bus_stop();
    send_pw(8'h80, P, a); wait_idle(); poll(a); check("R6 write uses write pw", a, 0); bus_stop();

    p0 = npulse;
    bus_start(); send_byte(8'h80, a);
    for (int i = 0; i < 3; i++) send_byte(8'h00, a);
    poll(a); check("R11 start abort poll nack", a, 0); bus_stop();
    bus_start(); send_byte(8'h80, a);
    for (int i = 0; i < 3; i++) send_byte(8'h00, a);
    bus_stop(); repeat (4) @(posedge clk); #1;
    check("R11 no pulse on abort", npulse - p0, 0);
    poll(a); check("R11 stop abort poll nack", a, 0); bus_stop();

    send_pw(8'h9B, P, a); wait_idle(); poll(a); check("R5 poll before cs test", a, 1);
    m_low = 0;
    repeat (2) begin wait_h(); scl = 1; wait_h(); scl = 0; end
    wait_h(); check("R7 bit5 of D0h driven low", dut_low, 1);
    cs_n = 1; repeat (8) @(posedge clk); #1;
    check("R13 sda released on cs high", dut_low, 0);
    cs_n = 0; wait_h();
    poll(a); check("R13 transfer abandoned", a, 0); bus_stop();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule